// File: doc/BRIEF.md
# Multiphase-Select Bit Clock Recovery

This block recovers a bit clock and retimed data from an oversampled demodulator stream. It runs entirely in a fast clock domain at sixteen times the bit rate. A free-running slot counter stands in for sixteen evenly spaced copies of the bit clock. Choosing a slot index is the same as choosing one of those clock phases. A transition detector watches the sliced data stream and reports the slot in which each level change lands. A phase estimator turns those positions into a selected slot.

After reset, the estimator is in acquisition. It collects the first four transitions and places the sampling slot half a bit away from their mean position, so this first choice can land anywhere. From then on it tracks. Each later transition votes early or late, and the selected slot moves by one place only after a run of votes in the same direction builds up.

A second input carries the slicer's raw decisions, about twelve per bit, each marked by a strobe. These are integrated over one bit window and dumped by majority at the selected slot. That produces one retimed bit and a one-cycle valid pulse.

Top module: `bitclk_recover`

## Requirements
- R1: After reset, `locked_o`, `bit_o` and `bit_vld_o` are 0 and `phase_sel_o` is 0. The slot counter is 0 in the first cycle after reset and advances by one each clock, modulo 16.
- R2: A transition occurs in the cycle when `din_i` differs from its value sampled on the previous clock. Its position is the slot counter value in that cycle.
- R3: On the fourth transition after reset, `locked_o` rises. The selected slot becomes (p1 + m + 8) mod 16, where p1 is the first position and each later position pk gives the offset ((pk - p1) mod 16) read as a signed value in -8..7. m is the floor of the sum of the offsets over the four transitions divided by 4. `locked_o` then stays 1 until reset.
- R4: While `locked_o` is 0, `bit_vld_o` stays 0.
- R5: When locked, each transition at slot p gives an error e = ((p - sel - 8) mod 16), read as signed. A running count rises by 1 when e > 0 and falls by 1 when e < 0; e = 0 leaves it unchanged. When the count reaches +5, the selected slot moves to sel+1 and the count clears. When it reaches -5, the selected slot moves to sel-1 and the count clears.
- R6: When locked, the selected slot changes by at most one place per step, however large the error is.
- R7: When locked, a dump occurs on the clock edge where the slot counter equals the selected slot. The dump counts the decisions with `dec_vld_i`=1 and `dec_bit_i`=1 since the previous dump, including that cycle. `bit_o` becomes 1 when the count is at least 7, otherwise 0, and `bit_vld_o` is 1 for exactly the following cycle.
- R8: `rclk_o` is 1 when ((slot - sel) mod 16) < 8, otherwise 0.
- R9: Slot arithmetic wraps modulo 16: a step above 15 gives 0 and a step below 0 gives 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 16 cycles per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| din_i | input | 1 | Sliced data stream used for transition detection |
| dec_vld_i | input | 1 | Strobe marking a slicer decision in this cycle |
| dec_bit_i | input | 1 | Value of the decision marked by dec_vld_i |
| rclk_o | output | 1 | Recovered bit clock |
| phase_sel_o | output | 4 | Selected sampling slot |
| locked_o | output | 1 | Acquisition finished, tracking active |
| bit_o | output | 1 | Retimed majority-voted bit |
| bit_vld_o | output | 1 | One-cycle pulse when bit_o is updated |

## Verification
The bench builds the block with its default values: 16 slots, acquisition over 4 transitions, a tracking limit of 4 and a vote threshold of 7. With these values, all 16 starting slots under four jitter patterns (including negative mean offsets that test floor rounding) can be swept. Every vote count from 0 to 12 in a window can also be covered, so the 6/7 boundary is hit exactly. Tracking is driven with small errors, large errors, cancelling errors and zero errors, and runs through the 15-to-0 wrap in both directions.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
    typedef enum logic {
        EST_ACQ = 1'b0,
        EST_TRK = 1'b1
    } est_mode_e;
endpackage

// File: rtl/cdr_edge_det.sv
module cdr_edge_det #(
    parameter int PH_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   din_i,
    input  logic [PH_W-1:0]        slot_i,
    input  logic [PH_W-1:0]        ref_i,
    output logic                   edge_o,
    output logic [PH_W-1:0]        pos_o,
    output logic signed [PH_W-1:0] err_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = din_i;
        edge_o = din_i ^ prev_q;
        pos_o  = slot_i;
        err_o  = slot_i - ref_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/cdr_phase_est.sv
module cdr_phase_est
    import cdr_pkg::*;
#(
    parameter int PH_W    = 4,
    parameter int ACQ_N   = 4,
    parameter int TRK_LIM = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   edge_i,
    input  logic [PH_W-1:0]        pos_i,
    input  logic signed [PH_W-1:0] err_i,
    output logic [PH_W-1:0]        sel_o,
    output logic                   locked_o
);
    localparam int ACQ_SH = $clog2(ACQ_N);
    localparam int SUM_W  = PH_W + ACQ_SH;
    localparam int ACC_W  = $clog2(TRK_LIM + 2) + 1;
    localparam int HALF   = (1 << PH_W) / 2;
    localparam logic signed [ACC_W-1:0] LIM_S = ACC_W'(TRK_LIM);

    typedef struct packed {
        est_mode_e          mode;
        logic [ACQ_SH-1:0]  cnt;
        logic [PH_W-1:0]    first;
        logic [SUM_W-1:0]   sum;
        logic [PH_W-1:0]    sel;
        logic [ACC_W-1:0]   acc;
    } est_t;

    est_t s_d, s_q;
    logic signed [PH_W-1:0]  delta;
    logic signed [SUM_W-1:0] tot;
    logic signed [SUM_W-1:0] avg;
    logic signed [ACC_W-1:0] step;
    logic signed [ACC_W-1:0] nacc;

    always_comb begin
        s_d   = s_q;
        delta = pos_i - s_q.first;
        tot   = $signed(s_q.sum) + $signed({{(SUM_W-PH_W){delta[PH_W-1]}}, delta});
        avg   = tot >>> ACQ_SH;
        if (err_i[PH_W-1])      step = -ACC_W'(1);
        else if (err_i != '0)   step = ACC_W'(1);
        else                    step = '0;
        nacc  = $signed(s_q.acc) + step;
        if (edge_i) begin
            if (s_q.mode == EST_ACQ) begin
                if (s_q.cnt == '0) begin
                    s_d.first = pos_i;
                    s_d.sum   = '0;
                    s_d.cnt   = ACQ_SH'(1);
                end else if (s_q.cnt == ACQ_SH'(ACQ_N - 1)) begin
                    s_d.sel  = s_q.first + avg[PH_W-1:0] + PH_W'(HALF);
                    s_d.mode = EST_TRK;
                    s_d.acc  = '0;
                    s_d.cnt  = '0;
                end else begin
                    s_d.sum = tot;
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end else begin
                if (nacc > LIM_S) begin
                    s_d.sel = s_q.sel + 1'b1;
                    s_d.acc = '0;
                end else if (nacc < -LIM_S) begin
                    s_d.sel = s_q.sel - 1'b1;
                    s_d.acc = '0;
                end else begin
                    s_d.acc = nacc;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{mode: EST_ACQ, default: '0};
        else        s_q <= s_d;
    end

    assign sel_o    = s_q.sel;
    assign locked_o = (s_q.mode == EST_TRK);

    // R6
    adj_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> (sel_o == $past(sel_o) ||
                      sel_o == PH_W'($past(sel_o) + 1'b1) ||
                      sel_o == PH_W'($past(sel_o) - 1'b1)));
    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o);
    // R5
    acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(s_q.acc) <= LIM_S) && ($signed(s_q.acc) >= -LIM_S));
endmodule

// File: rtl/cdr_vote.sv
module cdr_vote #(
    parameter int NPH      = 16,
    parameter int VOTE_THR = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic dump_i,
    input  logic dec_vld_i,
    input  logic dec_bit_i,
    output logic bit_o,
    output logic vld_o
);
    localparam int CNT_W = $clog2(NPH + 2);

    typedef struct packed {
        logic [CNT_W-1:0] ones;
        logic             bitv;
        logic             vld;
    } vote_t;

    vote_t v_d, v_q;
    logic [CNT_W-1:0] ones_now;

    always_comb begin
        v_d      = v_q;
        ones_now = v_q.ones;
        if (dec_vld_i && dec_bit_i && (v_q.ones != '1))
            ones_now = v_q.ones + 1'b1;
        if (!en_i) begin
            v_d.ones = '0;
            v_d.vld  = 1'b0;
        end else if (dump_i) begin
            v_d.bitv = (ones_now >= CNT_W'(VOTE_THR));
            v_d.ones = '0;
            v_d.vld  = 1'b1;
        end else begin
            v_d.ones = ones_now;
            v_d.vld  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign bit_o = v_q.bitv;
    assign vld_o = v_q.vld;

    // R4
    dump_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> $past(en_i));
    // R7
    ones_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_q.ones <= CNT_W'(NPH + 1));
endmodule

// File: rtl/bitclk_recover.sv
module bitclk_recover #(
    parameter int NPH      = 16,
    parameter int ACQ_N    = 4,
    parameter int TRK_LIM  = 4,
    parameter int VOTE_THR = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din_i,
    input  logic       dec_vld_i,
    input  logic       dec_bit_i,
    output logic       rclk_o,
    output logic [$clog2(NPH)-1:0] phase_sel_o,
    output logic       locked_o,
    output logic       bit_o,
    output logic       bit_vld_o
);
    localparam int PH_W = $clog2(NPH);
    localparam int HALF = NPH / 2;

    logic [PH_W-1:0]        slot_d, slot_q;
    logic [PH_W-1:0]        sel, ref_slot, pos;
    logic signed [PH_W-1:0] err;
    logic                   edge_seen, locked, dump;

    always_comb begin
        slot_d   = slot_q + 1'b1;
        ref_slot = sel + PH_W'(HALF);
        dump     = locked && (slot_q == sel);
        rclk_o   = (PH_W'(slot_q - sel) < PH_W'(HALF));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    cdr_edge_det #(.PH_W(PH_W)) u_det (
        .clk(clk), .rst_n(rst_n), .din_i(din_i), .slot_i(slot_q),
        .ref_i(ref_slot), .edge_o(edge_seen), .pos_o(pos), .err_o(err)
    );

    cdr_phase_est #(.PH_W(PH_W), .ACQ_N(ACQ_N), .TRK_LIM(TRK_LIM)) u_est (
        .clk(clk), .rst_n(rst_n), .edge_i(edge_seen), .pos_i(pos),
        .err_i(err), .sel_o(sel), .locked_o(locked)
    );

    cdr_vote #(.NPH(NPH), .VOTE_THR(VOTE_THR)) u_vote (
        .clk(clk), .rst_n(rst_n), .en_i(locked), .dump_i(dump),
        .dec_vld_i(dec_vld_i), .dec_bit_i(dec_bit_i),
        .bit_o(bit_o), .vld_o(bit_vld_o)
    );

    assign phase_sel_o = sel;
    assign locked_o    = locked;
endmodule

// File: tb/tb_bitclk_recover.sv
module tb_bitclk_recover;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, din, dvld, dbit;
    logic rclk, locked, bitv, bvld;
    logic [3:0] sel;

    int slot, checks, fails, sel_m, acc_m;
    logic lvl, done;

    bitclk_recover dut (
        .clk(clk), .rst_n(rst_n), .din_i(din), .dec_vld_i(dvld), .dec_bit_i(dbit),
        .rclk_o(rclk), .phase_sel_o(sel), .locked_o(locked),
        .bit_o(bitv), .bit_vld_o(bvld)
    );

    function automatic int w16(int x);
        return ((x % 16) + 16) % 16;
    endfunction

    function automatic int fdiv4(int s);
        return (s - (((s % 4) + 4) % 4)) / 4;
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(logic d, logic v, logic b);
        din = d; dvld = v; dbit = b;
        @(posedge clk);
        #2;
        slot = (slot + 1) % 16;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; din = 1'b0; dvld = 1'b0; dbit = 1'b0; lvl = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1; slot = 0;
    endtask

    task automatic edge_at(int pos);
        repeat (4) tick(lvl, 1'b0, 1'b0);
        while (slot != pos) tick(lvl, 1'b0, 1'b0);
        lvl = ~lvl;
        tick(lvl, 1'b0, 1'b0);
    endtask

    // bench-side tracking expectation from R5/R9
    task automatic track_edge(int off);
        int e;
        edge_at(w16(sel_m + 8 + off));
        e = w16(off);
        if (e >= 8) e = e - 16;
        if (e > 0) acc_m++;
        else if (e < 0) acc_m--;
        if (acc_m > 4) begin sel_m = w16(sel_m + 1); acc_m = 0; end
        else if (acc_m < -4) begin sel_m = w16(sel_m - 1); acc_m = 0; end
    endtask

    task automatic lock_at(int b);
        do_reset();
        for (int i = 0; i < 4; i++) edge_at(b);
        sel_m = w16(b + 8); acc_m = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        done = 1'b0;
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int pat [4][4];
        int bad;
        checks = 0; fails = 0;
        pat[0] = '{0, 0, 0, 0};
        pat[1] = '{0, 1, -1, 2};
        pat[2] = '{2, -1, -3, -1};
        pat[3] = '{-3, 1, 3, 2};

        // R1 reset state
        do_reset();
        check("R1", locked, 0, "locked after reset");
        check("R1", sel, 0, "sel after reset");
        check("R1", bitv, 0, "bit after reset");
        check("R1", bvld, 0, "bit_vld after reset");

        // R2 R3 R4: acquisition sweep over every start slot and jitter pattern
        for (int b = 0; b < 16; b++) begin
            for (int p = 0; p < 4; p++) begin
                int s;
                do_reset();
                for (int i = 0; i < 3; i++) edge_at(w16(b + pat[p][i]));
                check("R3", locked, 0, "locked before fourth transition");
                check("R4", bvld, 0, "bit_vld before lock");
                edge_at(w16(b + pat[p][3]));
                s = 0;
                for (int i = 1; i < 4; i++) s += pat[p][i] - pat[p][0];
                check("R3", locked, 1, "locked after fourth transition");
                check("R2", sel, w16(b + pat[p][0] + fdiv4(s) + 8), "acquired slot");
            end
        end

        // R5 R6: tracking
        lock_at(0);
        check("R3", sel, 8, "sel after clean lock");
        for (int i = 0; i < 4; i++) track_edge(1);
        check("R5", sel, 8, "sel after four late votes");
        track_edge(1);
        check("R5", sel, 9, "sel after fifth late vote");
        for (int i = 0; i < 5; i++) track_edge(-3);
        check("R5", sel, 8, "sel after five early votes");
        for (int i = 0; i < 4; i++) track_edge(6);
        check("R6", sel, 8, "sel after four large late errors");
        track_edge(6);
        check("R6", sel, 9, "single step on large error");
        for (int i = 0; i < 10; i++) track_edge((i % 2 == 0) ? 2 : -2);
        check("R5", sel, sel_m, "alternating votes cancel");
        check("R5", sel, 9, "alternating votes hold slot");
        for (int i = 0; i < 6; i++) track_edge(0);
        check("R5", sel, 9, "zero error leaves slot");
        check("R3", locked, 1, "lock held while tracking");

        // R9 wrap
        lock_at(7);
        check("R9", sel, 15, "lock at top slot");
        for (int i = 0; i < 5; i++) track_edge(1);
        check("R9", sel, 0, "wrap upward");
        for (int i = 0; i < 5; i++) track_edge(-1);
        check("R9", sel, 15, "wrap downward");

        // R8 recovered clock
        lock_at(0);
        for (int i = 0; i < 16; i++) begin
            tick(lvl, 1'b0, 1'b0);
            check("R8", rclk, (w16(slot - 8) < 8) ? 1 : 0, "rclk level");
        end

        // R7 majority vote over every count 0..12
        for (int k = 0; k <= 12; k++) begin
            tick(lvl, 1'b0, 1'b0);
            while (slot != 9) tick(lvl, 1'b0, 1'b0);
            bad = 0;
            for (int i = 0; i < 16; i++) begin
                tick(lvl, (i < 12) ? 1'b1 : 1'b0, (i < k) ? 1'b1 : 1'b0);
                if (i < 15 && bvld) bad++;
            end
            check("R7", bitv, (k >= 7) ? 1 : 0, $sformatf("vote with %0d ones", k));
            check("R7", bvld, 1, "bit_vld at dump");
            check("R7", bad, 0, "no bit_vld inside window");
        end
        tick(lvl, 1'b0, 1'b0);
        check("R7", bvld, 0, "bit_vld lasts one cycle");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule